// File: doc/BRIEF.md
# SDRAM Init and Refresh Sequencer

This block sits on the controller side of an SDRAM memory port. It wakes the device after reset and then keeps it refreshed. It first waits out a power-up delay. It then issues a single precharge-all, a programmable number of auto-refresh commands and one mode register load, and only then raises a ready flag. The mode word on the address lines is fixed: burst of 8 beats, sequential ordering, CAS latency 2, standard operation, and writes that burst at the programmed length.

Once ready, a two-stage refresh timer paces the refresh work. The first stage divides the clock by 32. The second stage is a count-down whose reload value comes in on a pin. Each expiry of the timer adds one owed refresh, and at most two are kept. While a refresh is owed and the block is idle, `ref_req` is raised toward the read/write arbiter. It behaves as a valid/ready pair: `ref_req` is valid and `ref_ack` is ready. A refresh is handed over on a rising edge where both are high. When the arbiter back-pressures by holding `ref_ack` low, `ref_req` stays high and further expiries pile up to the limit of two. An accepted refresh is carried out as precharge-all followed by one auto-refresh.

Command encodings on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, precharge-all 0010, auto-refresh 0001, mode register set 0000. Every command is held for exactly one cycle, and NOP is driven in all other cycles. All spacings are given in clock cycles and must be at least 2.

Top module: `sdram_upkeep`

## Requirements
- R1: While reset is asserted the outputs show NOP (0111), `addr` = 0, `ba` = 0, `init_done` = 0 and `ref_req` = 0.
- R2: The first command is precharge-all (0010), seen exactly WAIT_PWR rising edges after reset is released, with `addr` bit 10 set (all banks). NOP is driven before it.
- R3: During start-up the only commands are, in this order, one precharge-all, then INIT_REFS auto-refresh (0001) commands, then one mode register set (0000).
- R4: The command after a precharge-all comes T_RP cycles after it, and the command after an auto-refresh comes T_RFC cycles after it. Each command lasts one cycle, with NOP in between. `init_done` rises T_MRD cycles after the mode register set.
- R5: During the mode register set, `addr` = 0x023, and `ba` = 0. The bit layout is: bits 2:0 burst length 011 (8 beats), bit 3 burst type 0 (sequential), bits 6:4 CAS latency 010, bits 8:7 operating mode 00, bit 9 write-burst mode 0.
- R6: Timer expiries occur 32×(reload_val+1) cycles after `init_done` rises and then every 32×(reload_val+1) cycles. The first one raises `ref_req` in that same cycle.
- R7: `ref_req` stays high until it is accepted (`ref_req` and `ref_ack` both high on a rising edge). `ref_req` is never high before `init_done`.
- R8: An accepted refresh shows precharge-all in the cycle after acceptance, and auto-refresh T_RP cycles later. `ref_req` is low during this service. If a refresh is still owed, `ref_req` is raised again T_RP+T_RFC cycles after acceptance.
- R9: The number of owed refreshes saturates at 2. After three expiries with no acceptance, exactly two refreshes are serviced before the next expiry.
- R10: `ref_ack` has no effect while `ref_req` is low: no command is issued.
- R11: `init_done` stays high once set. After start-up, no command is issued except as the service of an accepted refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_val | input | RELOAD_W | Refresh timer reload value, sampled when `init_done` rises and at each expiry |
| ref_ack | input | 1 | Arbiter ready: takes the owed refresh |
| ref_req | output | 1 | Refresh owed and block idle (valid) |
| init_done | output | 1 | Device initialized and ready for traffic |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Device address lines |

## Verification
Every command is registered: a command decided at rising edge k is visible on the pins from edge k until edge k+1. The bench counts rising edges from reset release, samples just after each falling edge, and logs every non-NOP command with the edge count at which it appeared. From the parameters, the bench computes the start-up schedule: precharge-all at WAIT_PWR, the n-th refresh at WAIT_PWR+T_RP+(n-1)·T_RFC, the mode load one T_RFC after the last refresh, and `init_done` T_MRD after that. Timer expiries are expected at multiples of 32×(reload+1) after `init_done`. For each acceptance at edge a, the bench expects precharge-all at a and auto-refresh at a+T_RP, and it compares each logged entry and each handshake level against these exact cycles. The acknowledge delays are randomized, and the saturation case is set up by withholding acknowledgement over three expiries.

// File: rtl/upk_pkg.sv
package upk_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } upk_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_INIT_RP,
    ST_INIT_RFC,
    ST_INIT_MRD,
    ST_IDLE,
    ST_SVC_RP,
    ST_SVC_RFC
  } upk_state_e;

  localparam logic [2:0] BURST_LEN_8  = 3'b011;
  localparam logic       BURST_SEQ    = 1'b0;
  localparam logic [2:0] CAS_LAT_2    = 3'b010;
  localparam logic [1:0] OPMODE_STD   = 2'b00;
  localparam logic       WBURST_PROG = 1'b0;
  localparam int         PALL_ADDR_BIT = 10;

  function automatic logic [9:0] pack_mode(input logic [2:0] blen, input logic btype,
                                           input logic [2:0] clat, input logic [1:0] opm,
                                           input logic wbm);
    return {wbm, opm, clat, btype, blen};
  endfunction

  localparam logic [9:0] MODE_WORD =
    pack_mode(BURST_LEN_8, BURST_SEQ, CAS_LAT_2, OPMODE_STD, WBURST_PROG);

endpackage

// File: rtl/upk_cmd_drive.sv
module upk_cmd_drive
  import upk_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  upk_cmd_e          issue,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = '0;
    case (issue)
      CMD_PALL: addr_d[PALL_ADDR_BIT] = 1'b1;
      CMD_MRS:  addr_d[9:0] = MODE_WORD;
      default:  addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_n  <= CMD_NOP[3];
      ras_n <= CMD_NOP[2];
      cas_n <= CMD_NOP[1];
      we_n  <= CMD_NOP[0];
      addr  <= '0;
    end else begin
      cs_n  <= issue[3];
      ras_n <= issue[2];
      cas_n <= issue[1];
      we_n  <= issue[0];
      addr  <= addr_d;
    end
  end

endmodule

// File: rtl/upk_refresh_timer.sv
module upk_refresh_timer #(
  parameter int PRESCALE = 32,
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                load,
  input  logic [RELOAD_W-1:0] reload,
  output logic                expire
);

  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam bit POW2  = (PRESCALE & (PRESCALE - 1)) == 0;

  logic [PRE_W-1:0]    pre;
  logic                pre_last;
  logic [RELOAD_W-1:0] rcnt;

  generate
    if (POW2) begin : gen_pow2
      assign pre_last = &pre;
      always_ff @(posedge clk) begin
        if (!rst_n || load) pre <= '0;
        else if (en)        pre <= pre + 1'b1;
      end
    end else begin : gen_any
      assign pre_last = (pre == PRE_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || load) pre <= '0;
        else if (en)        pre <= pre_last ? '0 : pre + 1'b1;
      end
    end
  endgenerate

  assign expire = en && pre_last && (rcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0;
    end else if (load) begin
      rcnt <= reload;
    end else if (en && pre_last) begin
      rcnt <= (rcnt == '0) ? reload : rcnt - 1'b1;
    end
  end

endmodule

// File: rtl/upk_pend_ctr.sv
module upk_pend_ctr #(
  parameter int MAX_PEND = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic owed
);

  localparam int CW = $clog2(MAX_PEND + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt != CW'(MAX_PEND)) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign owed = (cnt != '0);

endmodule

// File: rtl/sdram_upkeep.sv
module sdram_upkeep
  import upk_pkg::*;
#(
  parameter int WAIT_PWR  = 20000,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 8,
  parameter int PRESCALE  = 32,
  parameter int RELOAD_W  = 8,
  parameter int PEND_MAX  = 2,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload_val,
  input  logic                ref_ack,
  output logic                ref_req,
  output logic                init_done,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BA_W-1:0]     ba,
  output logic [ADDR_W-1:0]   addr
);

  localparam int MAX_A  = (WAIT_PWR > T_RFC) ? WAIT_PWR : T_RFC;
  localparam int MAX_B  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAXW   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAXW + 1);
  localparam int REFS_W = $clog2(INIT_REFS + 1);

  upk_state_e        state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [REFS_W-1:0] refs, refs_n;
  logic              done_n;
  logic              tload;
  logic              owed;
  logic              expire;
  logic              accept;
  logic              cnt_zero;
  upk_cmd_e          issue;

  assign cnt_zero = (cnt == '0);
  assign ref_req  = (state == ST_IDLE) && owed;
  assign accept   = ref_req && ref_ack;
  assign ba       = '0;

  always_comb begin
    state_n = state;
    cnt_n   = cnt_zero ? cnt : cnt - 1'b1;
    refs_n  = refs;
    done_n  = init_done;
    tload   = 1'b0;
    issue   = CMD_NOP;
    case (state)
      ST_PWR: if (cnt_zero) begin
        issue   = CMD_PALL;
        state_n = ST_INIT_RP;
        cnt_n   = CNT_W'(T_RP - 1);
      end
      ST_INIT_RP: if (cnt_zero) begin
        issue   = CMD_REF;
        state_n = ST_INIT_RFC;
        cnt_n   = CNT_W'(T_RFC - 1);
        refs_n  = REFS_W'(1);
      end
      ST_INIT_RFC: if (cnt_zero) begin
        if (refs != REFS_W'(INIT_REFS)) begin
          issue  = CMD_REF;
          cnt_n  = CNT_W'(T_RFC - 1);
          refs_n = refs + 1'b1;
        end else begin
          issue   = CMD_MRS;
          state_n = ST_INIT_MRD;
          cnt_n   = CNT_W'(T_MRD - 1);
        end
      end
      ST_INIT_MRD: if (cnt_zero) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
        tload   = 1'b1;
      end
      ST_IDLE: if (accept) begin
        issue   = CMD_PALL;
        state_n = ST_SVC_RP;
        cnt_n   = CNT_W'(T_RP - 1);
      end
      ST_SVC_RP: if (cnt_zero) begin
        issue   = CMD_REF;
        state_n = ST_SVC_RFC;
        cnt_n   = CNT_W'(T_RFC - 1);
      end
      ST_SVC_RFC: if (cnt_zero) begin
        state_n = ST_IDLE;
      end
      default: state_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PWR;
      cnt       <= CNT_W'(WAIT_PWR - 1);
      refs      <= '0;
      init_done <= 1'b0;
    end else begin
      state     <= state_n;
      cnt       <= cnt_n;
      refs      <= refs_n;
      init_done <= done_n;
    end
  end

  upk_refresh_timer #(
    .PRESCALE (PRESCALE),
    .RELOAD_W (RELOAD_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (init_done),
    .load   (tload),
    .reload (reload_val),
    .expire (expire)
  );

  upk_pend_ctr #(
    .MAX_PEND (PEND_MAX)
  ) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (expire),
    .dec   (accept),
    .owed  (owed)
  );

  upk_cmd_drive #(
    .ADDR_W (ADDR_W)
  ) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr)
  );

endmodule

// File: rtl/upk_checker.sv
module upk_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_ack,
  input logic              ref_req,
  input logic              init_done,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr
);

  logic [3:0] bus_cmd;
  assign bus_cmd = {cs_n, ras_n, cas_n, we_n};

  // R4: a command occupies one cycle only
  a_r4_one_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 4'b0111) |=> (bus_cmd == 4'b0111));

  // R5: mode word on the address lines
  a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 4'b0000) |-> (addr == ADDR_W'(10'h023)));

  // R2: precharge-all selects all banks
  a_r2_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 4'b0010) |-> addr[10]);

  // R11: ready flag never drops
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7: no request before ready
  a_r7_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);

  // R7: request held under back-pressure
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  // R8: acceptance starts service with precharge-all
  a_r8_accept_pall: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=> (bus_cmd == 4'b0010) && !ref_req);

endmodule

bind sdram_upkeep upk_checker #(.ADDR_W(ADDR_W)) u_upk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_ack   (ref_ack),
  .ref_req   (ref_req),
  .init_done (init_done),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr)
);

// File: tb/test_sdram_upkeep.sv
`timescale 1ns/1ps
module test_sdram_upkeep;

  localparam int WAIT_PWR  = 40;
  localparam int T_RP      = 3;
  localparam int T_RFC     = 6;
  localparam int T_MRD     = 2;
  localparam int INIT_REFS = 8;
  localparam int PRESCALE  = 32;
  localparam int ADDR_W    = 13;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PALL = 4'b0010;
  localparam logic [3:0] REF  = 4'b0001;
  localparam logic [3:0] MRS  = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic ref_ack = 1'b0;
  logic ref_req, init_done, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  always #10 clk = ~clk;

  sdram_upkeep #(
    .WAIT_PWR(WAIT_PWR), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .INIT_REFS(INIT_REFS), .PRESCALE(PRESCALE), .RELOAD_W(8), .PEND_MAX(2),
    .ADDR_W(ADDR_W), .BA_W(2)
  ) i_sdram_upkeep (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .ref_ack(ref_ack),
    .ref_req(ref_req), .init_done(init_done), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
  );

  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int               n_log = 0;
  int               log_cyc [256];
  logic [3:0]       log_cmd [256];
  logic [ADDR_W-1:0] log_addr [256];
  always @(negedge clk) begin
    if (rst_n && cmd != NOP && n_log < 256) begin
      log_cyc[n_log]  = cyc;
      log_cmd[n_log]  = cmd;
      log_addr[n_log] = addr;
      n_log = n_log + 1;
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic goto(input int t);
    while (cyc < t) step();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // expected start-up schedule
  function automatic int exp_init_cyc(input int i);
    if (i == 0) return WAIT_PWR;
    return WAIT_PWR + T_RP + (i - 1) * T_RFC;
  endfunction

  function automatic logic [3:0] exp_init_cmd(input int i);
    if (i == 0) return PALL;
    if (i <= INIT_REFS) return REF;
    return MRS;
  endfunction

  int rel;
  int exp_done;
  function automatic int ev(input int k);
    return exp_done + PRESCALE * (rel + 1) * k;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    rel = $urandom_range(0, 2);
    reload_val = 8'(rel);
    exp_done = exp_init_cyc(INIT_REFS + 1) + T_MRD;

    repeat (3) step();
    chk("R1 reset cmd", int'(cmd), int'(NOP));
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset ba", int'(ba), 0);
    chk("R1 reset init_done", int'(init_done), 0);
    chk("R1 reset ref_req", int'(ref_req), 0);
    rst_n = 1'b1;

    goto(WAIT_PWR - 1);
    chk("R2 nop before wait", int'(cmd), int'(NOP));
    goto(WAIT_PWR);
    chk("R2 first cmd pall", int'(cmd), int'(PALL));
    chk("R2 pall a10", int'(addr[10]), 1);

    while (!init_done) step();
    chk("R4 init_done cycle", cyc, exp_done);
    chk("R3 start-up cmd count", n_log, INIT_REFS + 2);
    for (int i = 0; i < INIT_REFS + 2; i++) begin
      chk($sformatf("R3 init cmd %0d", i), int'(log_cmd[i]), int'(exp_init_cmd(i)));
      chk($sformatf("R4 init cyc %0d", i), log_cyc[i], exp_init_cyc(i));
    end
    chk("R5 mode word", int'(log_addr[INIT_REFS + 1]), 'h023);

    // R6: first expiry timing
    goto(ev(1) - 1);
    chk("R6 no req before expiry", int'(ref_req), 0);
    goto(ev(1));
    chk("R6 req at expiry", int'(ref_req), 1);

    // R9 saturation: three expiries without acceptance
    goto(ev(3) + 1);
    chk("R7 req held unacked", int'(ref_req), 1);
    chk("R11 no unaccepted cmds", n_log, INIT_REFS + 2);
    base = n_log;
    ref_ack = 1'b1;
    goto(ev(3) + 2);
    chk("R8 req low in service", int'(ref_req), 0);
    goto(ev(4) - 1);
    chk("R9 two services only", n_log - base, 4);
    chk("R8 svc1 pall", int'(log_cmd[base]), int'(PALL));
    chk("R8 svc1 pall cyc", log_cyc[base], ev(3) + 2);
    chk("R8 svc1 ref", int'(log_cmd[base + 1]), int'(REF));
    chk("R8 svc1 ref cyc", log_cyc[base + 1], ev(3) + 2 + T_RP);
    chk("R8 svc2 pall cyc", log_cyc[base + 2], ev(3) + 3 + T_RP + T_RFC);
    chk("R8 svc2 ref cyc", log_cyc[base + 3], ev(3) + 3 + 2 * T_RP + T_RFC);

    // random acknowledge delays
    for (int k = 4; k < 12; k++) begin
      int d;
      ref_ack = 1'b0;
      chk($sformatf("R6 req idle before ev%0d", k), int'(ref_req), 0);
      base = n_log;
      goto(ev(k));
      chk($sformatf("R6 req at ev%0d", k), int'(ref_req), 1);
      d = $urandom_range(0, 5);
      goto(ev(k) + d);
      chk($sformatf("R7 req held d=%0d", d), int'(ref_req), 1);
      ref_ack = 1'b1;
      goto(ev(k) + d + 1);
      chk("R8 req drops on accept", int'(ref_req), 0);
      goto(ev(k + 1) - 1);
      chk("R10 ack ignored when idle", n_log - base, 2);
      chk("R8 pall after accept", log_cyc[base], ev(k) + d + 1);
      chk("R8 ref after pall", log_cyc[base + 1], ev(k) + d + 1 + T_RP);
      chk("R11 init_done kept", int'(init_done), 1);
    end

    finish_run();
  end

endmodule